// File: doc/BRIEF.md
# Sync-Pulse Decoder and Black-Level Clamp Gate

This block turns one combined line-timing pulse per video channel into black-level clamp enables. Each timing input carries one pulse per line that starts a little before and ends a little after the horizontal sync of the selected video. There is no separate vertical signal. Vertical blanking is found from the pulse width, because the pulses are longer on several lines of that interval. The block runs on the 13.5 MHz sample clock. It measures every pulse in clock cycles and opens a clamp window a fixed time after the pulse ends. While a channel is in vertical blanking, its clamp is suppressed, so the vertical sync cannot pull the black level.

There are two timing channels, primary and secondary. Each has a disable bit, which software sets when the line-lock loop has no lock. A select bit decides which channel's timing drives the clamp of the YUV path. If a channel's timing input shows no edges for a long time, its clamp output stays off until a new pulse begins.

Top module: `hv_clamp_gate`

## Requirements
- R1: Each timing input passes through two synchroniser flops before edge detection. A level driven before clock edge k is seen as an edge in the cycle that follows edge k+1.
- R2: A pulse counts as wide when it stays high for more than WIDE_THR cycles (default 100). A pulse of exactly WIDE_THR cycles counts as normal.
- R3: A channel's vertical flag (vblank_pri, vblank_sec) is set at the end of the second wide pulse in a row. It is cleared at the end of the second normal pulse in a row. A single wide pulse between normal pulses leaves the flag unchanged.
- R4: The clamp window opens CLAMP_DLY cycles after the cycle in which the falling edge is detected (default 8). It stays open for CLAMP_LEN cycles (default 32). A rising edge closes it early.
- R5: A channel's clamp stays low whenever that channel's vertical flag is set.
- R6: pri_disable forces clamp_pri low, and sec_disable forces clamp_sec low. Neither bit affects the other channel or clamp_yuv.
- R7: clamp_yuv follows the primary timing when yuv_from_sec is 0 and the secondary timing when it is 1. It uses that channel's window, vertical flag and idle state.
- R8: If a channel sees no edge for IDLE_LIM cycles (default 1024), it becomes idle. This clears its vertical flag and its wide and normal run counts, and holds its clamps low. It stays idle until a rising edge arrives, so a pulse that ends after the timeout does not clamp. A channel is also idle out of reset.
- R9: While reset is asserted, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.5 MHz sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hv_pri_async | input | 1 | Primary combined line-timing pulse, asynchronous |
| hv_sec_async | input | 1 | Secondary combined line-timing pulse, asynchronous |
| pri_disable | input | 1 | Register bit that suppresses the primary clamp |
| sec_disable | input | 1 | Register bit that suppresses the secondary clamp |
| yuv_from_sec | input | 1 | Register bit: 0 = YUV clamp from primary timing, 1 = from secondary |
| clamp_pri | output | 1 | Clamp enable for the primary channel |
| clamp_sec | output | 1 | Clamp enable for the secondary channel |
| clamp_yuv | output | 1 | Clamp enable for the YUV channel |
| vblank_pri | output | 1 | Vertical blanking flag from the primary timing |
| vblank_sec | output | 1 | Vertical blanking flag from the secondary timing |

## Verification
Take a timing input driven low just before clock edge k. The falling edge is seen after edge k+1. The vertical flag therefore changes after edge k+2. The clamp rises after edge k+2+CLAMP_DLY, which is 11 edges after the drive with the default values. The register bits act on the outputs in the same cycle, through logic only. The bench drives inputs on the falling clock edge. A behavioural reference model advances on each rising edge and is compared with all five outputs on each falling edge. Directed checks count clock edges from a drive to test the 11-edge clamp delay and the 3-edge flag delay.

// File: rtl/hv_clamp_pkg.sv
package hv_clamp_pkg;
  localparam int NUM_CH = 2;

  // Pulse classification: strictly longer than the threshold is wide.
  function automatic logic pulse_is_wide(input logic [31:0] high_cycles, input int unsigned thr);
    return high_cycles > thr;
  endfunction

  // Window position test: open for len cycles starting at position dly.
  function automatic logic window_open(input logic [31:0] pos, input int unsigned dly,
                                       input int unsigned len);
    return (pos >= dly) && (pos < dly + len);
  endfunction
endpackage

// File: rtl/hv_sync_edge.sv
module hv_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, stab_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
      hist_q <= stab_q;
    end
  end

  assign level_o = stab_q;
  assign rise_o  = stab_q & ~hist_q;
  assign fall_o  = ~stab_q & hist_q;

  // R1: an edge reflects the input level two samples earlier
  p_rise_sampled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> $past(async_i, 2));
  p_fall_sampled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> !$past(async_i, 2));
endmodule

// File: rtl/hv_line_tracker.sv
module hv_line_tracker #(
  parameter int unsigned WIDE_THR  = 100,
  parameter int unsigned SET_RUN   = 2,
  parameter int unsigned CLR_RUN   = 2,
  parameter int unsigned CLAMP_DLY = 8,
  parameter int unsigned CLAMP_LEN = 32,
  parameter int unsigned IDLE_LIM  = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic vblank_o,
  output logic win_o,
  output logic idle_o
);
  import hv_clamp_pkg::*;

  localparam int unsigned WMAX = WIDE_THR + 1;
  localparam int WCW = $clog2(WMAX + 1);
  localparam int unsigned RMAX = (SET_RUN > CLR_RUN) ? SET_RUN : CLR_RUN;
  localparam int RCW = $clog2(RMAX + 1);
  localparam int PCW = $clog2(CLAMP_DLY + CLAMP_LEN + 1);
  localparam int ICW = $clog2(IDLE_LIM + 1);

  logic [WCW-1:0] wcnt;
  logic [RCW-1:0] wide_run, norm_run;
  logic           vb_q, run_q, idle_q;
  logic [PCW-1:0] pcnt;
  logic [ICW-1:0] icnt;

  logic at_limit, go_idle, pulse_wide;
  assign at_limit   = (icnt == ICW'(IDLE_LIM));
  assign go_idle    = at_limit && !rise_i;
  assign pulse_wide = pulse_is_wide(32'(wcnt), WIDE_THR);

  // Width measurement in cycles, saturating one past the threshold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                wcnt <= '0;
    else if (rise_i)                           wcnt <= WCW'(1);
    else if (level_i && wcnt != WCW'(WMAX))    wcnt <= wcnt + 1'b1;
  end

  // Vertical flag with run-length hysteresis
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_run <= '0;
      norm_run <= '0;
      vb_q     <= 1'b0;
    end else if (go_idle) begin
      wide_run <= '0;
      norm_run <= '0;
      vb_q     <= 1'b0;
    end else if (fall_i) begin
      if (pulse_wide) begin
        norm_run <= '0;
        if (wide_run != RCW'(SET_RUN)) wide_run <= wide_run + 1'b1;
        if (32'(wide_run) + 1 >= SET_RUN) vb_q <= 1'b1;
      end else begin
        wide_run <= '0;
        if (norm_run != RCW'(CLR_RUN)) norm_run <= norm_run + 1'b1;
        if (32'(norm_run) + 1 >= CLR_RUN) vb_q <= 1'b0;
      end
    end
  end

  // Clamp window position after the trailing edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pcnt  <= '0;
    end else if (fall_i) begin
      run_q <= 1'b1;
      pcnt  <= '0;
    end else if (rise_i) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      pcnt <= pcnt + 1'b1;
      if (32'(pcnt) == CLAMP_DLY + CLAMP_LEN - 1) run_q <= 1'b0;
    end
  end

  // Loss-of-timing watchdog
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt   <= ICW'(IDLE_LIM);
      idle_q <= 1'b1;
    end else begin
      if (rise_i || fall_i) icnt <= '0;
      else if (!at_limit)   icnt <= icnt + 1'b1;
      if (rise_i)           idle_q <= 1'b0;
      else if (at_limit)    idle_q <= 1'b1;
    end
  end

  assign vblank_o = vb_q;
  assign win_o    = run_q && window_open(32'(pcnt), CLAMP_DLY, CLAMP_LEN);
  assign idle_o   = idle_q;

  // R3: the flag only moves on a trailing edge or on the idle timeout
  p_vb_moves_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vb_q) |-> ($past(fall_i) || $past(go_idle)));
  // R4: the window is shut in the cycle right after a trailing edge
  p_win_shut_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((CLAMP_DLY > 0) && fall_i) |=> !win_o);
  // R8: idle persists until a rising edge
  p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && !rise_i) |=> idle_q);
endmodule

// File: rtl/hv_clamp_gate.sv
module hv_clamp_gate #(
  parameter int unsigned WIDE_THR  = 100,
  parameter int unsigned SET_RUN   = 2,
  parameter int unsigned CLR_RUN   = 2,
  parameter int unsigned CLAMP_DLY = 8,
  parameter int unsigned CLAMP_LEN = 32,
  parameter int unsigned IDLE_LIM  = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hv_pri_async,
  input  logic hv_sec_async,
  input  logic pri_disable,
  input  logic sec_disable,
  input  logic yuv_from_sec,
  output logic clamp_pri,
  output logic clamp_sec,
  output logic clamp_yuv,
  output logic vblank_pri,
  output logic vblank_sec
);
  import hv_clamp_pkg::*;

  logic [NUM_CH-1:0] hv_in, lvl, rise, fall, vb, win, idle, timing_ok, ch_dis;

  assign hv_in  = {hv_sec_async, hv_pri_async};
  assign ch_dis = {sec_disable, pri_disable};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    hv_sync_edge u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(hv_in[c]),
      .level_o(lvl[c]), .rise_o(rise[c]), .fall_o(fall[c])
    );
    hv_line_tracker #(
      .WIDE_THR(WIDE_THR), .SET_RUN(SET_RUN), .CLR_RUN(CLR_RUN),
      .CLAMP_DLY(CLAMP_DLY), .CLAMP_LEN(CLAMP_LEN), .IDLE_LIM(IDLE_LIM)
    ) u_trk (
      .clk(clk), .rst_n(rst_n), .level_i(lvl[c]), .rise_i(rise[c]), .fall_i(fall[c]),
      .vblank_o(vb[c]), .win_o(win[c]), .idle_o(idle[c])
    );
    assign timing_ok[c] = win[c] & ~vb[c] & ~idle[c];
  end

  assign clamp_pri  = timing_ok[0] & ~ch_dis[0];
  assign clamp_sec  = timing_ok[1] & ~ch_dis[1];
  assign clamp_yuv  = yuv_from_sec ? timing_ok[1] : timing_ok[0];
  assign vblank_pri = vb[0];
  assign vblank_sec = vb[1];

  // R7: the YUV clamp never fires during blanking of its selected source
  p_yuv_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_yuv |-> !(yuv_from_sec ? vblank_sec : vblank_pri));
  // R5: no channel clamps inside its own blanking interval
  p_sec_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_sec |-> !clamp_sec);
endmodule

// File: tb/hv_clamp_gate_test.sv
`timescale 1ns/1ps
module hv_clamp_gate_test;
  localparam int THR = 100, SETR = 2, CLRR = 2, DLY = 8, LEN = 32, IDL = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hv [2];
  logic pri_disable = 1'b0, sec_disable = 1'b0, yuv_from_sec = 1'b0;
  logic clamp_pri, clamp_sec, clamp_yuv, vblank_pri, vblank_sec;
  int errors = 0, checks = 0;
  bit done = 0, live = 0;

  always #2.5 clk = ~clk;

  hv_clamp_gate uut (
    .clk(clk), .rst_n(rst_n), .hv_pri_async(hv[0]), .hv_sec_async(hv[1]),
    .pri_disable(pri_disable), .sec_disable(sec_disable), .yuv_from_sec(yuv_from_sec),
    .clamp_pri(clamp_pri), .clamp_sec(clamp_sec), .clamp_yuv(clamp_yuv),
    .vblank_pri(vblank_pri), .vblank_sec(vblank_sec)
  );

  task automatic check(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", what, got, exp, $time);
    end
  endtask

  // Behavioural reference: history of samples plus per-channel counters
  int hq [2][$];
  int wlen[2], wrn[2], nrn[2], vbm[2], opn[2], pos[2], quiet[2], idl[2];

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (!rst_n) begin
        hq[c] = '{0, 0, 0};
        wlen[c] = 0; wrn[c] = 0; nrn[c] = 0; vbm[c] = 0;
        opn[c] = 0; pos[c] = 0; quiet[c] = IDL; idl[c] = 1;
      end else begin
        int now_hi, was_hi, up, dn, timeout, wide;
        now_hi  = hq[c][hq[c].size()-2];
        was_hi  = hq[c][hq[c].size()-3];
        up      = now_hi && !was_hi;
        dn      = !now_hi && was_hi;
        timeout = (quiet[c] == IDL) && !up;
        wide    = wlen[c] > THR;
        if (up) wlen[c] = 1; else if (now_hi && wlen[c] <= THR) wlen[c]++;
        if (timeout) begin wrn[c] = 0; nrn[c] = 0; vbm[c] = 0; end
        else if (dn) begin
          if (wide) begin
            nrn[c] = 0;
            if (wrn[c] + 1 >= SETR) vbm[c] = 1;
            wrn[c] = (wrn[c] + 1 > SETR) ? SETR : wrn[c] + 1;
          end else begin
            wrn[c] = 0;
            if (nrn[c] + 1 >= CLRR) vbm[c] = 0;
            nrn[c] = (nrn[c] + 1 > CLRR) ? CLRR : nrn[c] + 1;
          end
        end
        if (dn) begin opn[c] = 1; pos[c] = 0; end
        else if (up) opn[c] = 0;
        else if (opn[c]) begin
          if (pos[c] == DLY + LEN - 1) opn[c] = 0;
          pos[c]++;
        end
        if (up) idl[c] = 0; else if (quiet[c] == IDL) idl[c] = 1;
        if (up || dn) quiet[c] = 0; else if (quiet[c] < IDL) quiet[c]++;
        hq[c].push_back(int'(hv[c]));
        void'(hq[c].pop_front());
      end
    end
  end

  function automatic logic ok_model(input int c);
    return opn[c] && pos[c] >= DLY && pos[c] < DLY + LEN && !vbm[c] && !idl[c];
  endfunction

  always @(negedge clk) begin
    if (live && rst_n) begin
      check(clamp_pri, ok_model(0) && !pri_disable, "R4/R5/R6/R8 clamp_pri");
      check(clamp_sec, ok_model(1) && !sec_disable, "R4/R5/R6/R8 clamp_sec");
      check(clamp_yuv, yuv_from_sec ? ok_model(1) : ok_model(0), "R7 clamp_yuv");
      check(vblank_pri, logic'(vbm[0]), "R2/R3 vblank_pri");
      check(vblank_sec, logic'(vbm[1]), "R2/R3 vblank_sec");
    end
  end

  task automatic line(input int c, input int hi, input int lo);
    hv[c] = 1'b1; repeat (hi) @(negedge clk);
    hv[c] = 1'b0; repeat (lo) @(negedge clk);
  endtask

  task automatic run_pri();
    for (int i = 0; i < 5; i++) begin
      if (i == 2) begin
        hv[0] = 1'b1; repeat (30) @(negedge clk);
        hv[0] = 1'b0;
        for (int e = 1; e <= 11; e++) begin
          @(negedge clk);
          if (e >= 10) check(clamp_pri, logic'(e == 11), "R1/R4 clamp delay from trailing edge");
        end
        repeat (159) @(negedge clk);
      end else line(0, 30, 170);
    end
    for (int i = 0; i < 4; i++) begin
      if (i == 1) begin
        hv[0] = 1'b1; repeat (120) @(negedge clk);
        hv[0] = 1'b0;
        for (int e = 1; e <= 3; e++) begin
          @(negedge clk);
          if (e >= 2) check(vblank_pri, logic'(e == 3), "R3 flag delay on second wide pulse");
        end
        repeat (77) @(negedge clk);
      end else line(0, 120, 80);
    end
    for (int i = 0; i < 4; i++) line(0, 30, 170);
    repeat (1200) @(negedge clk);
    for (int i = 0; i < 3; i++) line(0, 30, 170);
    hv[0] = 1'b1; repeat (1100) @(negedge clk);
    hv[0] = 1'b0; repeat (20) @(negedge clk);
    check(clamp_pri, 1'b0, "R8 no clamp after over-long pulse");
    repeat (180) @(negedge clk);
    for (int i = 0; i < 3; i++) line(0, 30, 170);
  endtask

  task automatic run_sec();
    for (int i = 0; i < 3; i++) line(1, 40, 180);
    line(1, 101, 120);
    for (int i = 0; i < 2; i++) line(1, 40, 180);
    for (int i = 0; i < 3; i++) line(1, 100, 120);
    for (int i = 0; i < 3; i++) line(1, 101, 120);
    for (int i = 0; i < 4; i++) line(1, 40, 180);
    for (int i = 0; i < 6; i++) line(1, 20, 200);
  endtask

  task automatic run_regs();
    repeat (1200) @(negedge clk); pri_disable = 1'b1;
    repeat (500)  @(negedge clk); pri_disable = 1'b0;
    repeat (800)  @(negedge clk); yuv_from_sec = 1'b1;
    repeat (500)  @(negedge clk); sec_disable = 1'b1;
    repeat (600)  @(negedge clk); sec_disable = 1'b0;
    repeat (1400) @(negedge clk); yuv_from_sec = 1'b0;
  endtask

  initial begin
    hv[0] = 1'b0; hv[1] = 1'b0;
    repeat (3) @(negedge clk);
    check(clamp_pri, 1'b0, "R9 reset clamp_pri");
    check(clamp_sec, 1'b0, "R9 reset clamp_sec");
    check(clamp_yuv, 1'b0, "R9 reset clamp_yuv");
    check(vblank_pri, 1'b0, "R9 reset vblank_pri");
    check(vblank_sec, 1'b0, "R9 reset vblank_sec");
    rst_n = 1'b1; live = 1;
    fork
      run_pri();
      run_sec();
      run_regs();
    join
    repeat (20) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule